// File: doc/BRIEF.md
# Polled Command-Handshake Device Port

This block is the device-side end of a programmed-I/O link. A host reaches it through a small register bus with one-cycle strobes. It finds four registers there: status, command, an inbound byte and an outbound byte. The host never waits on an interrupt. It polls the busy flag until the flag reads clear. It then loads the outbound byte, picks a direction in the command register, and raises the command-ready flag as a separate write.

Once the controller sees command-ready, it claims the port by setting busy. For an output it offers the outbound byte on a valid/ready device interface; for an input it accepts one byte from the device into the inbound register. When the device side finishes or reports a fault, completion follows a fixed order. First command-ready drops and the error flag takes the outcome. One cycle later busy drops. A host that touches the command or outbound registers while busy gets no effect, and a sticky violation flag records the attempt.

Top module: `pio_port`

## Requirements
- R1: After reset every register reads zero, dev_tx_valid and dev_rx_ready are low.
- R2: Offsets are 0 status, 1 command, 2 inbound byte, 3 outbound byte. Status bit 0 is busy, bit 1 is error, bit 2 is violation. Command bit 0 is command-ready and bit 1 selects output (1) or input (0). The outbound and command registers read back what was written while idle. bus_rdata is zero when bus_rd is low.
- R3: Busy reads clear in the cycle after the edge that stores command-ready. It reads set after the following edge.
- R4: During an output command, dev_tx_valid is high only while busy. It presents the outbound byte and holds it unchanged until dev_tx_ready or dev_fault. dev_tx_valid and dev_rx_ready are never both high.
- R5: After the device handshake edge, command-ready clears one edge later while busy stays set. Busy clears on the edge after that. On success the error flag is clear.
- R6: A fault seen during the transfer sets the error flag. Command-ready and busy still clear in the same order as in R5. An input command that faults leaves the inbound register unchanged.
- R7: During an input command, dev_rx_ready is high only while busy. The byte on dev_rx_data at the dev_rx_valid edge lands in the inbound register.
- R8: Writes to offsets 1 or 3 while busy leave those registers unchanged and set the violation flag.
- R9: The violation flag stays set until a status write with bit 2 high. A status write never alters busy or error.
- R10: Writes to the inbound register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | Read enable, gates bus_rdata |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| dev_tx_valid | output | 1 | Outbound byte offered |
| dev_tx_ready | input | 1 | Device takes outbound byte |
| dev_tx_data | output | DATA_W | Outbound byte |
| dev_rx_valid | input | 1 | Device offers inbound byte |
| dev_rx_ready | output | 1 | Controller takes inbound byte |
| dev_rx_data | input | DATA_W | Inbound byte |
| dev_fault | input | 1 | Device reports a failed transfer |

## Verification
The bench targets the completion order. A design that drops busy together with command-ready, or before it, lets a polling host start a new command while the old one still looks pending. The bench therefore samples both flags on each of the two edges after the device handshake. It also writes during busy and then reads back the command and outbound registers, which catches a design that lets the write through or forgets the sticky flag. Faults on input commands confirm that an aborted read does not corrupt the inbound register. Varied device stall lengths show whether the outbound byte drifts while dev_tx_valid waits.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_fault
);
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd1;
  localparam logic [1:0] OFS_IN   = 2'd2;
  localparam logic [1:0] OFS_OUT  = 2'd3;
  localparam int PAD = DATA_W - 3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE, S_FIN} st_t;

  st_t st_q;
  logic busy_q, err_q, viol_q, cmd_q, dir_q, fault_q;
  logic [DATA_W-1:0] dout_q, din_q;

  wire wr_stat = bus_wr && (bus_addr == OFS_STAT);
  wire wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  wire wr_out  = bus_wr && (bus_addr == OFS_OUT);
  wire in_xfer = (st_q == S_XFER);

  assign dev_tx_valid = in_xfer && dir_q;
  assign dev_rx_ready = in_xfer && !dir_q;
  assign dev_tx_data  = dout_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_STAT: bus_rdata = {{PAD{1'b0}}, viol_q, err_q, busy_q};
        OFS_CMD:  bus_rdata = {{(DATA_W-2){1'b0}}, dir_q, cmd_q};
        OFS_IN:   bus_rdata = din_q;
        default:  bus_rdata = dout_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      viol_q  <= 1'b0;
      cmd_q   <= 1'b0;
      dir_q   <= 1'b0;
      fault_q <= 1'b0;
      dout_q  <= '0;
      din_q   <= '0;
    end else begin
      if (wr_stat && bus_wdata[2]) viol_q <= 1'b0;
      if ((wr_cmd || wr_out) && busy_q) viol_q <= 1'b1;
      if (wr_cmd && !busy_q) {dir_q, cmd_q} <= bus_wdata[1:0];
      if (wr_out && !busy_q) dout_q <= bus_wdata;

      unique case (st_q)
        S_IDLE: if (cmd_q) begin
          busy_q  <= 1'b1;
          fault_q <= 1'b0;
          st_q    <= S_XFER;
        end
        S_XFER: begin
          if (dev_fault) begin
            fault_q <= 1'b1;
            st_q    <= S_DONE;
          end else if (dir_q ? dev_tx_ready : dev_rx_valid) begin
            if (!dir_q) din_q <= dev_rx_data;
            st_q <= S_DONE;
          end
        end
        S_DONE: begin
          cmd_q <= 1'b0;
          err_q <= fault_q;
          st_q  <= S_FIN;
        end
        default: begin
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              cmd_rdy,
  input logic              viol,
  input logic [DATA_W-1:0] data_out,
  input logic              dev_tx_valid,
  input logic              dev_tx_ready,
  input logic [DATA_W-1:0] dev_tx_data,
  input logic              dev_rx_ready,
  input logic              dev_fault
);
  AST_TX_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) dev_tx_valid |-> busy); // R4
  AST_RX_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) dev_rx_ready |-> busy); // R7
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n) !(dev_tx_valid && dev_rx_ready)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid && !dev_tx_ready && !dev_fault |=> dev_tx_valid && $stable(dev_tx_data)); // R4
  AST_CMD_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !cmd_rdy && $past(!cmd_rdy)); // R5
  AST_OUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && bus_addr == 2'd3 |=> $stable(data_out)); // R8
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd3) |=> viol); // R8
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol && !(bus_wr && bus_addr == 2'd0 && bus_wdata[2]) |=> viol); // R9
endmodule

bind pio_port pio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .busy(busy_q), .cmd_rdy(cmd_q), .viol(viol_q),
  .data_out(dout_q), .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
  .dev_tx_data(dev_tx_data), .dev_rx_ready(dev_rx_ready), .dev_fault(dev_fault)
);

// File: tb/pio_port_tb.sv
module pio_port_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic dev_tx_valid, dev_tx_ready = 0, dev_rx_valid = 0, dev_rx_ready, dev_fault = 0;
  logic [7:0] dev_tx_data, dev_rx_data = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_in = 0;
  bit exp_viol = 0;

  always #10 clk = ~clk;

  pio_port #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_tx_valid(dev_tx_valid),
    .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data), .dev_rx_valid(dev_rx_valid),
    .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data), .dev_fault(dev_fault)
  );

  function automatic logic [7:0] stat_of(bit b, bit e, bit v);
    return {5'b0, v, e, b};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
    #1;
  endtask

  task automatic txn(bit is_out, logic [7:0] data, int stall, bit fault, bit poke);
    logic [7:0] s, c, rx;
    rd_reg(0, s);
    while (s[0]) begin @(negedge clk); rd_reg(0, s); end
    if (is_out) begin
      wr_reg(3, data); wr_reg(1, 8'h02); wr_reg(1, 8'h03);
    end else wr_reg(1, 8'h01);
    rd_reg(0, s); chk("R3 busy still clear", s[0], 0);
    @(negedge clk);
    rd_reg(0, s); chk("R3 busy set", s[0], 1);
    if (is_out) begin
      chk("R4 tx valid", dev_tx_valid, 1); chk("R4 tx data", dev_tx_data, data);
    end else chk("R7 rx ready", dev_rx_ready, 1);
    if (poke) begin
      wr_reg(3, ~data); wr_reg(1, 8'h00);
      exp_viol = 1;
      rd_reg(1, c); chk("R8 cmd locked", c, is_out ? 8'h03 : 8'h01);
      rd_reg(3, c); chk("R8 out locked", c, is_out ? data : c);
      rd_reg(0, s); chk("R8 violation", s[2], 1);
    end
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (is_out) chk("R4 hold", dev_tx_data, data);
      chk("R4 valid hold", dev_tx_valid, is_out);
    end
    rx = 8'($urandom);
    if (fault) dev_fault = 1;
    else if (is_out) dev_tx_ready = 1;
    else begin dev_rx_valid = 1; dev_rx_data = rx; end
    @(negedge clk);
    dev_fault = 0; dev_tx_ready = 0; dev_rx_valid = 0;
    chk("R4 valid drops", dev_tx_valid, 0);
    rd_reg(1, c); chk("R5 cmd held", c[0], 1);
    @(negedge clk);
    rd_reg(1, c); chk("R5 cmd cleared first", c[0], 0);
    rd_reg(0, s); chk(fault ? "R6 busy still set" : "R5 busy still set", s, stat_of(1, fault, exp_viol));
    @(negedge clk);
    if (!is_out && !fault) exp_in = rx;
    rd_reg(0, s); chk(fault ? "R6 final status" : "R5 final status", s, stat_of(0, fault, exp_viol));
    rd_reg(2, c); chk(is_out ? "R7 in kept" : (fault ? "R6 in kept" : "R7 in captured"), c, exp_in);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v); chk("R1 reg zero", v, 0);
    end
    chk("R1 tx idle", dev_tx_valid, 0); chk("R1 rx idle", dev_rx_ready, 0);
    chk("R2 rdata gated", bus_rdata, 0);
    wr_reg(3, 8'hA5); rd_reg(3, v); chk("R2 out readback", v, 8'hA5);
    wr_reg(1, 8'h02); rd_reg(1, v); chk("R2 cmd readback", v, 8'h02);
    wr_reg(1, 8'h00);
    wr_reg(2, 8'hFF); rd_reg(2, v); chk("R10 in write ignored", v, 0);
    wr_reg(0, 8'h03); rd_reg(0, v); chk("R9 status write no effect", v, 0);
    txn(1, 8'h3C, 0, 0, 0);
    txn(0, 8'h00, 2, 0, 0);
    txn(1, 8'hC3, 3, 1, 0);
    txn(0, 8'h00, 1, 1, 0);
    txn(1, 8'h5A, 2, 0, 1);
    wr_reg(0, 8'h03); rd_reg(0, v); chk("R9 sticky", v, stat_of(0, 0, 1));
    wr_reg(0, 8'h04); exp_viol = 0; rd_reg(0, v); chk("R9 cleared", v, 0);
    for (int n = 0; n < 40; n++) begin
      bit p;
      p = ($urandom % 6) == 0;
      txn(1'($urandom), 8'($urandom), int'($urandom % 4), ($urandom % 5) == 0, p);
      if (p) begin wr_reg(0, 8'h04); exp_viol = 0; end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule